// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. It steers an analog input multiplexer, opens and closes a sample-and-hold switch, and runs a 12-bit binary search. In that search it drives a trial code to an external DAC and reads back one comparator bit per clock. Each finished code goes into a 16-bit result register that belongs to the converted channel. The register keeps the code in its low 12 bits and clears its top 4 bits.

There are three ways to run. Single mode converts one chosen channel once. Multi mode walks through a group of channels once, in ascending order. Scan mode repeats that walk pass after pass until it is told to stop. A group is channels 0 to 3 or channels 0 to 7.

A run is launched by one of three trigger sources: a software start bit, an internal timer pulse or an external trigger pin. An end-of-conversion pulse marks each completed set of channels.

The trigger, configuration, analog-control and interrupt pins are plain control signals. The results are held in registers and read through a combinational read port, so the block has no valid/ready stream interface and applies no back-pressure.

Top module: `sar_adc_seq`

## Requirements
- R1: Single mode (`mode_sel`=0, and also 3) converts channel `chan_sel` once. `eoc_irq` goes high S+12 clock edges after the edge that accepts the trigger. S is `sample_clks`, and a value of 0 counts as 1.
- R2: A conversion makes 12 bit decisions, MSB first. Each decision drives the accumulated code with the trial bit set on `dac_code`, and keeps that bit when `comp_in` is 1 (input at or above the DAC level). With an ideal comparator the stored code equals the 12-bit input.
- R3: Each channel's conversion starts with S cycles in which `sh_hold` is 0 and `mux_sel` shows the channel. These are followed by exactly 12 cycles with `sh_hold` at 1.
- R4: `mux_sel` stays constant for as long as `sh_hold` is 1.
- R5: Multi mode (`mode_sel`=1) converts channels 0..3 (`group8`=0) or 0..7 (`group8`=1) once each, in ascending order. It raises a single `eoc_irq` N*(S+12) edges after the trigger, where N is the group size.
- R6: Scan mode (`mode_sel`=2) repeats passes over the group and pulses `eoc_irq` at the end of every pass. A `stop_scan` pulse received while busy ends the run at the end of the current pass.
- R7: Every channel has its own result register, reset to 0. `rd_data` = {4'b0, code} of the channel on `rd_chan`, and a channel that is not converted keeps its value.
- R8: `src_sel` 0 selects `sw_start`, 1 selects `timer_trig`, 2 selects a rising edge of `ext_trig`, and 3 selects no source. Sources that are not selected are ignored, and holding `ext_trig` high starts only one run.
- R9: A trigger that arrives while `busy` is 1 is ignored. It changes neither the timing nor the channel order, and it starts no additional run.
- R10: After reset `busy`, `sh_hold`, `eoc_irq` and `dac_code` are 0. `busy` is 1 from the cycle after the accepted trigger until the end of the run, and `eoc_irq` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Run mode: 0 single, 1 multi, 2 scan, 3 single |
| group8 | input | 1 | Group size for multi/scan: 0 = 4 channels, 1 = 8 channels |
| chan_sel | input | 3 | Channel converted in single mode |
| src_sel | input | 2 | Trigger source: 0 software, 1 timer, 2 external edge, 3 none |
| sample_clks | input | 8 | Sample phase length in clocks (0 treated as 1) |
| sw_start | input | 1 | Software start pulse |
| timer_trig | input | 1 | Internal timer trigger pulse |
| ext_trig | input | 1 | External trigger pin (rising edge) |
| stop_scan | input | 1 | Pulse to end scan mode after the current pass |
| comp_in | input | 1 | Comparator: 1 when held input is at or above the DAC level |
| mux_sel | output | 3 | Analog multiplexer channel select |
| sh_hold | output | 1 | 0 = sample (track), 1 = hold during bit decisions |
| dac_code | output | 12 | Trial code to the DAC; 0 while not converting |
| busy | output | 1 | A run is in progress |
| eoc_irq | output | 1 | One-cycle end-of-conversion interrupt pulse |
| rd_chan | input | 3 | Result register select |
| rd_data | output | 16 | Selected result, right-justified 12-bit code |

## Verification
The comparator is modelled as an ideal analog one that holds the multiplexed input when `sh_hold` rises. The input values are chosen so that codes 0, 1, 4095, the mid-scale step 2048/2047 and the alternating patterns 0x555/0xAAA are all converted. These patterns separate a wrong keep/discard rule, a bit-order fault and a stuck trial bit.

The runs cover single, four- and eight-channel multi mode and two-pass scan mode. Each run has its own sample length, including the zero case, so a wrong channel order, a wrong per-channel latency or a missing end-of-pass pulse shows up as a count or order mismatch. Extra pulses on unselected sources, a held external pin and a mid-run trigger show whether any of them wrongly starts a conversion or disturbs the one in progress.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_ALT    = 2'd3
  } conv_mode_t;

  typedef enum logic [1:0] {
    SRC_SW    = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_NONE  = 2'd3
  } trig_src_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel
  import sar_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trig_src_t src_sel,
  input  logic      sw_start,
  input  logic      timer_trig,
  input  logic      ext_trig,
  output logic      trig
);
  logic ext_q;
  logic ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  assign ext_rise = ext_trig & ~ext_q;

  always_comb begin
    case (src_sel)
      SRC_SW:    trig = sw_start;
      SRC_TIMER: trig = timer_trig;
      SRC_EXT:   trig = ext_rise;
      default:   trig = 1'b0;
    endcase
  end

  // R8: an external trigger only counts on a low-to-high step
  assert_ext_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_EXT && trig) |-> !ext_q);
endmodule

// File: rtl/sar_bit_search.sv
module sar_bit_search #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             comp_in,
  output logic             active,
  output logic             last,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = $clog2(RES_W);

  logic [RES_W-1:0] acc;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] trial;

  assign trial    = acc | (RES_W'(1) << idx);
  assign dac_code = active ? trial : '0;
  assign last     = active && (idx == '0);
  assign result   = comp_in ? trial : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      acc    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= IDX_W'(RES_W - 1);
      acc    <= '0;
    end else if (active) begin
      acc <= result;
      if (idx == '0) active <= 1'b0;
      else           idx    <= idx - 1'b1;
    end
  end

  // R2: decisions walk from MSB down one bit per clock
  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && idx != '0) |=> (active && idx == $past(idx) - 1'b1));

  // R2: the decided bit equals the comparator answer of that clock
  assert_keep_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (acc[$past(idx)] == $past(comp_in)));
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int NCH   = 8,
  parameter int RES_W = 12,
  parameter int REG_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_chan,
  input  logic [RES_W-1:0]       wr_data,
  input  logic [$clog2(NCH)-1:0] rd_chan,
  output logic [REG_W-1:0]       rd_data
);
  logic [RES_W-1:0] regs_view [NCH];

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    logic [RES_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  code_q <= '0;
      else if (wr_en && wr_chan == $clog2(NCH)'(g)) code_q <= wr_data;
    end
    assign regs_view[g] = code_q;
  end

  assign rd_data = REG_W'(regs_view[rd_chan]);

  // R7: a write lands in the addressed channel register
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_view[$past(wr_chan)] == $past(wr_data)));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int SMP_W = 8,
  parameter int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  conv_mode_t       mode_sel,
  input  logic             group8,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [SMP_W-1:0] sample_clks,
  input  logic             stop_scan,
  input  logic             conv_last,
  output logic             conv_start,
  output logic             wr_en,
  output logic [CH_W-1:0]  wr_chan,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sh_hold,
  output logic             busy,
  output logic             eoc
);
  localparam logic [CH_W-1:0] LAST8 = CH_W'(NCH - 1);
  localparam logic [CH_W-1:0] LAST4 = CH_W'(NCH / 2 - 1);

  seq_state_t       state;
  conv_mode_t       cfg_mode;
  logic             cfg_group8;
  logic [SMP_W-1:0] cfg_smp;
  logic [SMP_W-1:0] cnt;
  logic [CH_W-1:0]  chan;
  logic             stop_req;
  logic [SMP_W-1:0] smp_m1;
  logic             is_group;
  logic             pass_end;
  logic             cnt_done;

  assign smp_m1   = (cfg_smp == '0) ? '0 : cfg_smp - 1'b1;
  assign is_group = (cfg_mode == MODE_MULTI) || (cfg_mode == MODE_SCAN);
  assign pass_end = !is_group || (chan == (cfg_group8 ? LAST8 : LAST4));
  assign cnt_done = (state == ST_SAMPLE) && (cnt == smp_m1);

  assign conv_start = cnt_done;
  assign wr_en      = (state == ST_CONV) && conv_last;
  assign wr_chan    = chan;
  assign mux_sel    = chan;
  assign sh_hold    = (state == ST_CONV);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cfg_mode   <= MODE_SINGLE;
      cfg_group8 <= 1'b0;
      cfg_smp    <= '0;
      cnt        <= '0;
      chan       <= '0;
      stop_req   <= 1'b0;
      eoc        <= 1'b0;
    end else begin
      eoc <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (trig) begin
            state      <= ST_SAMPLE;
            cnt        <= '0;
            cfg_mode   <= mode_sel;
            cfg_group8 <= group8;
            cfg_smp    <= sample_clks;
            stop_req   <= 1'b0;
            chan       <= (mode_sel == MODE_MULTI || mode_sel == MODE_SCAN) ? '0 : chan_sel;
          end
        end
        ST_SAMPLE: begin
          if (cnt_done) state <= ST_CONV;
          else          cnt   <= cnt + 1'b1;
        end
        ST_CONV: begin
          if (conv_last) begin
            cnt <= '0;
            if (pass_end) begin
              eoc <= 1'b1;
              if (cfg_mode == MODE_SCAN && !(stop_req || stop_scan)) begin
                chan  <= '0;
                state <= ST_SAMPLE;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              chan  <= chan + 1'b1;
              state <= ST_SAMPLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (state != ST_IDLE && stop_scan) stop_req <= 1'b1;
    end
  end

  // R4: channel cannot move while the input is held
  assert_hold_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_hold && $past(sh_hold)) |-> $stable(mux_sel));

  // R3: channel stays put through the sample phase
  assert_sample_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAMPLE && !cnt_done) |=> $stable(mux_sel));

  // R2: the search finishes only while the sequencer is holding
  assert_conv_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_last |-> (state == ST_CONV));

  // R9: a trigger mid-sample does not restart the sample count
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAMPLE && trig && !cnt_done) |=> (state == ST_SAMPLE && cnt == $past(cnt) + 1'b1));

  // R10: end-of-conversion is a single-cycle pulse
  assert_eoc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 12,
  parameter int REG_W = 16,
  parameter int SMP_W = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             group8,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [1:0]       src_sel,
  input  logic [SMP_W-1:0] sample_clks,
  input  logic             sw_start,
  input  logic             timer_trig,
  input  logic             ext_trig,
  input  logic             stop_scan,
  input  logic             comp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sh_hold,
  output logic [RES_W-1:0] dac_code,
  output logic             busy,
  output logic             eoc_irq,
  input  logic [CH_W-1:0]  rd_chan,
  output logic [REG_W-1:0] rd_data
);
  logic             trig;
  logic             conv_start;
  logic             conv_active;
  logic             conv_last;
  logic [RES_W-1:0] conv_result;
  logic             wr_en;
  logic [CH_W-1:0]  wr_chan;

  sar_trig_sel u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (trig_src_t'(src_sel)),
    .sw_start   (sw_start),
    .timer_trig (timer_trig),
    .ext_trig   (ext_trig),
    .trig       (trig)
  );

  sar_seq #(.NCH(NCH), .SMP_W(SMP_W), .CH_W(CH_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .mode_sel    (conv_mode_t'(mode_sel)),
    .group8      (group8),
    .chan_sel    (chan_sel),
    .sample_clks (sample_clks),
    .stop_scan   (stop_scan),
    .conv_last   (conv_last),
    .conv_start  (conv_start),
    .wr_en       (wr_en),
    .wr_chan     (wr_chan),
    .mux_sel     (mux_sel),
    .sh_hold     (sh_hold),
    .busy        (busy),
    .eoc         (eoc_irq)
  );

  sar_bit_search #(.RES_W(RES_W)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (conv_start),
    .comp_in  (comp_in),
    .active   (conv_active),
    .last     (conv_last),
    .dac_code (dac_code),
    .result   (conv_result)
  );

  sar_result_bank #(.NCH(NCH), .RES_W(RES_W), .REG_W(REG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_chan (wr_chan),
    .wr_data (conv_result),
    .rd_chan (rd_chan),
    .rd_data (rd_data)
  );

  // R3: the search engine runs exactly while the input is held
  assert_hold_matches_search_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_hold == conv_active);
endmodule

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  localparam int NCH = 8, RES_W = 12, REG_W = 16, SMP_W = 8, CH_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_sel;
  logic group8;
  logic [CH_W-1:0] chan_sel;
  logic [1:0] src_sel;
  logic [SMP_W-1:0] sample_clks;
  logic sw_start, timer_trig, ext_trig, stop_scan;
  logic comp_in;
  logic [CH_W-1:0] mux_sel;
  logic sh_hold;
  logic [RES_W-1:0] dac_code;
  logic busy, eoc_irq;
  logic [CH_W-1:0] rd_chan;
  logic [REG_W-1:0] rd_data;

  always #5 clk = ~clk;

  sar_adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .group8(group8),
    .chan_sel(chan_sel), .src_sel(src_sel), .sample_clks(sample_clks),
    .sw_start(sw_start), .timer_trig(timer_trig), .ext_trig(ext_trig),
    .stop_scan(stop_scan), .comp_in(comp_in), .mux_sel(mux_sel),
    .sh_hold(sh_hold), .dac_code(dac_code), .busy(busy), .eoc_irq(eoc_irq),
    .rd_chan(rd_chan), .rd_data(rd_data)
  );

  // analog model: ideal sample-and-hold feeding an ideal comparator
  logic [RES_W-1:0] vin [NCH];
  logic [RES_W-1:0] held = '0;
  always @(posedge sh_hold) held = vin[mux_sel];
  assign comp_in = (held >= dac_code);

  typedef struct packed { logic [CH_W-1:0] ch; logic [RES_W-1:0] val; } item_t;
  item_t exp_q[$];
  item_t pend[$];

  int vectors = 0;
  int miscompares = 0;
  int exp_smp = 1;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int ch, input int val);
    item_t it;
    vin[ch] = val[RES_W-1:0];
    it.ch = ch[CH_W-1:0];
    it.val = val[RES_W-1:0];
    exp_q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    bit prev_hold = 0;
    int low_cnt = 0;
    int hold_cnt = 0;
    item_t it;
    rd_chan = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sh_hold && !prev_hold) begin
          if (exp_q.size() == 0) chk(0, "R5 unexpected conversion", mux_sel, -1);
          else begin
            it = exp_q.pop_front();
            chk(mux_sel == it.ch, "R5 channel order", mux_sel, it.ch);
            chk(low_cnt == exp_smp, "R3 sample length", low_cnt, exp_smp);
            pend.push_back(it);
          end
          low_cnt = 0;
          hold_cnt = 1;
        end else if (sh_hold) begin
          hold_cnt++;
        end else if (prev_hold) begin
          chk(hold_cnt == 12, "R3 hold length", hold_cnt, 12);
          hold_cnt = 0;
        end
        if (busy && !sh_hold) low_cnt++;
        if (eoc_irq) begin
          foreach (pend[i]) begin
            rd_chan = pend[i].ch;
            #1;
            chk(rd_data == {4'b0, pend[i].val}, "R2 R7 result code", rd_data, {4'b0, pend[i].val});
          end
          pend.delete();
        end
        prev_hold = sh_hold;
      end
    end
  end

  // trigger and count edges to eoc; mid >= 0 adds a software pulse at that cycle
  task automatic launch(input int src, input int exp_k, input int mid, input string tag);
    int c = 0;
    @(negedge clk);
    case (src)
      0: sw_start = 1'b1;
      1: timer_trig = 1'b1;
      default: ext_trig = 1'b1;
    endcase
    do begin
      @(negedge clk);
      c++;
      if (c == 1) begin
        sw_start = 1'b0; timer_trig = 1'b0; ext_trig = 1'b0;
        chk(busy == 1'b1, "R10 busy after trigger", busy, 1);
      end
      if (mid >= 0 && c == mid) sw_start = 1'b1;
      if (mid >= 0 && c == mid + 1) sw_start = 1'b0;
    end while (!eoc_irq && c < 5000);
    chk(c == exp_k + 1, tag, c, exp_k + 1);
  endtask

  task automatic stay_idle(input int n, input string tag);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (busy || eoc_irq) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic read_reg(input int ch, input int exp, input string tag);
    @(negedge clk);
    rd_chan = ch[CH_W-1:0];
    #1;
    chk(rd_data == exp[REG_W-1:0], tag, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int c;
    rst_n = 1'b0;
    mode_sel = 2'd0; group8 = 1'b0; chan_sel = '0; src_sel = 2'd0;
    sample_clks = 8'd4; sw_start = 0; timer_trig = 0; ext_trig = 0; stop_scan = 0;
    for (int i = 0; i < NCH; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && eoc_irq == 0 && sh_hold == 0, "R10 reset outputs", {busy, eoc_irq, sh_hold}, 0);
    chk(dac_code == 0, "R10 reset dac_code", dac_code, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) read_reg(i, 0, "R7 reset register");

    // R1 single, sample 4
    mode_sel = 2'd0; chan_sel = 3'd5; sample_clks = 8'd4; exp_smp = 4;
    push(5, 12'hABC);
    launch(0, 16, -1, "R1 single latency");
    // R1 single, sample 0 counts as 1, code 0
    chan_sel = 3'd0; sample_clks = 8'd0; exp_smp = 1;
    push(0, 0);
    launch(0, 13, -1, "R1 single latency with zero sample");
    // R1 single via mode 3, full scale
    mode_sel = 2'd3; chan_sel = 3'd7; sample_clks = 8'd1; exp_smp = 1;
    push(7, 12'hFFF);
    launch(0, 13, -1, "R1 mode3 single latency");
    read_reg(5, 16'h0ABC, "R7 channel 5 kept");
    read_reg(3, 0, "R7 channel 3 untouched");

    // R5 multi, 4 channels, timer source (R8)
    mode_sel = 2'd1; group8 = 0; sample_clks = 8'd3; exp_smp = 3; src_sel = 2'd1;
    push(0, 1); push(1, 12'h800); push(2, 12'h555); push(3, 12'hAAA);
    launch(1, 60, -1, "R5 R8 multi4 timer latency");
    // R5 multi, 8 channels, external source
    group8 = 1; sample_clks = 8'd2; exp_smp = 2; src_sel = 2'd2;
    push(0, 12'h7FF); push(1, 12'h001); push(2, 12'h3C3); push(3, 12'hF0F);
    push(4, 12'h800); push(5, 12'h123); push(6, 12'hFFE); push(7, 12'h400);
    launch(2, 112, -1, "R5 R8 multi8 external latency");
    read_reg(7, 16'h0400, "R7 channel 7 overwritten");

    // R9 trigger while busy
    group8 = 0; src_sel = 2'd0; exp_smp = 2;
    push(0, 12'h0F0); push(1, 12'h00F); push(2, 12'hE01); push(3, 12'h1FE);
    launch(0, 56, 20, "R9 latency with mid-run trigger");
    stay_idle(30, "R9 no extra run");
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

    // R8 unselected sources ignored
    src_sel = 2'd1;
    @(negedge clk); sw_start = 1; ext_trig = 1;
    @(negedge clk); sw_start = 0; ext_trig = 0;
    stay_idle(20, "R8 unselected sources");
    src_sel = 2'd3;
    @(negedge clk); timer_trig = 1; sw_start = 1;
    @(negedge clk); timer_trig = 0; sw_start = 0;
    stay_idle(20, "R8 no source selected");

    // R8 external held high starts one run only
    src_sel = 2'd2; mode_sel = 2'd0; chan_sel = 3'd2; sample_clks = 8'd5; exp_smp = 5;
    push(2, 12'h9A5);
    @(negedge clk); ext_trig = 1;
    c = 0;
    do begin @(negedge clk); c++; end while (!eoc_irq && c < 5000);
    chk(c == 18, "R8 held external latency", c, 18);
    stay_idle(30, "R8 held external no retrigger");
    ext_trig = 0;

    // R6 scan, two passes, stop during the second
    mode_sel = 2'd2; group8 = 0; sample_clks = 8'd1; exp_smp = 1; src_sel = 2'd0;
    push(0, 12'h321); push(1, 12'hCDE); push(2, 12'h002); push(3, 12'hFFD);
    launch(0, 52, -1, "R6 scan first pass latency");
    push(0, 12'h123); push(1, 12'hFED); push(2, 12'h800); push(3, 12'h7FF);
    @(negedge clk); stop_scan = 1;
    @(negedge clk); stop_scan = 0;
    c = 2;
    while (!eoc_irq && c < 5000) begin @(negedge clk); c++; end
    chk(c == 52, "R6 scan second pass latency", c, 52);
    @(negedge clk);
    chk(busy == 0, "R6 stopped after pass", busy, 0);
    stay_idle(30, "R6 no third pass");
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    read_reg(3, 16'h07FF, "R6 R7 second pass result");

    done = 1;
    finish_run();
  end
endmodule